// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block is a parameterised cache with one line per set. It sits between a processor port that reads and writes one addressable unit at a time and a next-level memory port that moves whole blocks. A request address is split into a tag, a set index and a block offset. The set index comes from the middle address bits, so neighbouring blocks land in different lines. Each line holds a valid flag, a stored tag, a data block and a dirty flag. The dirty flag is used only in write-back mode.

A lookup hits only when the indexed line is valid and its stored tag equals the request tag. A miss fetches the whole block and replaces the line of that set. A compile-time parameter selects one of two write policies:
- Write-through without allocation: every write is forwarded as a single-lane write, and a write miss leaves the cache untouched.
- Write-back with allocation: a write miss first fills the line, a write hit only marks the line dirty, and a dirty line is copied out in full when it is displaced.

The processor port takes one request at a time. The next-level port has two valid/ready channels: one for block refills and one for block or lane writes.

Top module: `dm_cache`

## Requirements
- R1: A request address is split, from the most significant bit down, into TAG_W = ADDR_W-IDX_W-OFF_W tag bits, IDX_W set bits and OFF_W offset bits. Next-level addresses are block numbers, equal to the byte address shifted right by OFF_W. With ADDR_W=4, IDX_W=2 and OFF_W=1, address 13 refills block 6.
- R2: After reset every line is invalid, so the first access to each set misses.
- R3: A read miss fetches exactly one whole block and installs it. A read returns the unit at its offset within the block, where unit j of a block occupies bits [j*DATA_W +: DATA_W] of the block data. A later read within the same resident block hits without any refill.
- R4: Each set holds one line, and a miss replaces it. With the small configuration of R1, the read trace 0, 1, 13, 8, 0 reports miss, hit, miss, miss, miss.
- R5: `req_ready_o` is high only while the block is idle. `rsp_done_o` is a one-cycle pulse. For a hit that needs no next-level traffic, `rsp_done_o` rises on the second falling edge after the request is driven. `rsp_hit_o` is 1 for a hit and 0 for a miss.
- R6: In write-through mode, a write hit updates the cached unit and issues one next-level write carrying the hit block's number, a one-hot lane mask whose bit is the offset, and the unit in that lane. The response follows the write handshake.
- R7: In write-through mode, a write miss issues the same single-lane write, starts no refill and leaves the cache unchanged, so a following read of that address misses.
- R8: In write-back mode, a write hit updates only the cached unit and marks the line dirty. No next-level write is issued.
- R9: In write-back mode, a write miss refills the block, then merges the written unit and reports a miss. A following read of that address hits and returns the written value.
- R10: In write-back mode, displacing a dirty line first writes the old block in full: its block number is {stored tag, set}, and all lane mask bits are 1. Only after that write does the refill start. Displacing a clean line issues no write.
- R11: `fill_valid_o` and `wb_valid_o` are never high together. Each stays high with stable address and data until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | processor request present |
| req_ready_o | output | 1 | cache idle and able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | unit address |
| req_wdata_i | input | DATA_W | write data |
| rsp_done_o | output | 1 | one-cycle completion pulse |
| rsp_hit_o | output | 1 | request hit, valid with done |
| rsp_rdata_o | output | DATA_W | read data, valid with done |
| fill_valid_o | output | 1 | refill request |
| fill_ready_i | input | 1 | refill data present this cycle |
| fill_addr_o | output | ADDR_W-OFF_W | block number to refill |
| fill_data_i | input | DATA_W<<OFF_W | refill block |
| wb_valid_o | output | 1 | next-level write request |
| wb_ready_i | input | 1 | next-level write accepted |
| wb_addr_o | output | ADDR_W-OFF_W | block number written |
| wb_data_o | output | DATA_W<<OFF_W | block or lane data |
| wb_be_o | output | 1<<OFF_W | lane mask |

## Verification
The bench uses 4-bit addresses, four sets and two-unit blocks. It runs one write-back instance and one write-through instance against memory models that answer with a delay. It replays the trace of R4 and sweeps every address twice, so every tag conflict in every set is exercised; a design that took the index from the top bits, or that did not check the valid bit, would report hits in the wrong places. It targets:
- a dirty eviction, where writing back the wrong block number or refilling before the write would corrupt next-level memory;
- a clean eviction, where a spurious write would show up in the write count;
- write misses under both policies, where allocating in write-through mode, or not allocating in write-back mode, flips the hit seen by the following read.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_WTHRU,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [OFF_W-1:0]  off_o
);
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
  assign idx_o = addr_i[OFF_W +: IDX_W];
  assign off_o = addr_i[OFF_W-1:0];
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 2,
  localparam int SETS  = 1 << IDX_W,
  localparam int BLK_W = DATA_W << OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BLK_W-1:0]  blk_o,
  input  logic              fill_en_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_dirty_i
);
  logic             valid_q [SETS];
  logic             dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS];
  logic [BLK_W-1:0] blk_q   [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    logic sel;
    assign sel = (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (sel) begin
        if (fill_en_i) begin
          valid_q[g] <= 1'b1;
          dirty_q[g] <= 1'b0;
        end else if (wr_en_i && wr_dirty_i) begin
          dirty_q[g] <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        if (fill_en_i) begin
          tag_q[g] <= fill_tag_i;
          blk_q[g] <= fill_blk_i;
        end else if (wr_en_i) begin
          blk_q[g][int'(wr_off_i)*DATA_W +: DATA_W] <= wr_data_i;
        end
      end
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign blk_o   = blk_q[idx_i];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic we_i,
  input  logic tag_match_i,
  input  logic line_valid_i,
  input  logic line_dirty_i,
  input  logic fill_ready_i,
  input  logic wb_ready_i,
  output logic req_ready_o,
  output logic load_o,
  output logic fill_valid_o,
  output logic fill_en_o,
  output logic wb_valid_o,
  output logic wb_evict_o,
  output logic wr_en_o,
  output logic cap_o,
  output logic done_o,
  output logic hit_o
);
  cache_state_e state_q, state_d;
  logic miss_q;
  logic hit;

  assign hit          = line_valid_i && tag_match_i;
  assign req_ready_o  = (state_q == ST_IDLE);
  assign load_o       = req_ready_o && req_valid_i;
  assign fill_valid_o = (state_q == ST_FILL);
  assign fill_en_o    = fill_valid_o && fill_ready_i;
  assign wb_evict_o   = (state_q == ST_EVICT);
  assign wb_valid_o   = wb_evict_o || (state_q == ST_WTHRU);
  assign cap_o        = (state_q == ST_LOOK) && hit;
  assign wr_en_o      = cap_o && we_i;
  assign done_o       = (state_q == ST_RESP);
  assign hit_o        = !miss_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_LOOK;
      ST_LOOK: begin
        if (we_i && !WRITE_BACK)                       state_d = ST_WTHRU;
        else if (hit)                                  state_d = ST_RESP;
        else if (WRITE_BACK && line_valid_i && line_dirty_i) state_d = ST_EVICT;
        else                                           state_d = ST_FILL;
      end
      ST_EVICT: if (wb_ready_i)   state_d = ST_FILL;
      ST_FILL:  if (fill_ready_i) state_d = ST_LOOK;
      ST_WTHRU: if (wb_ready_i)   state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) miss_q <= 1'b0;
      else if (state_q == ST_LOOK && !hit) miss_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 4,
  parameter int OFF_W      = 2,
  parameter int DATA_W     = 8,
  parameter bit WRITE_BACK = 1'b1,
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int WORDS     = 1 << OFF_W,
  localparam int BLK_W     = DATA_W << OFF_W,
  localparam int BADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_done_o,
  output logic               rsp_hit_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               fill_valid_o,
  input  logic               fill_ready_i,
  output logic [BADDR_W-1:0] fill_addr_o,
  input  logic [BLK_W-1:0]   fill_data_i,
  output logic               wb_valid_o,
  input  logic               wb_ready_i,
  output logic [BADDR_W-1:0] wb_addr_o,
  output logic [BLK_W-1:0]   wb_data_o,
  output logic [WORDS-1:0]   wb_be_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [TAG_W-1:0]  req_tag, line_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic              line_valid, line_dirty;
  logic [BLK_W-1:0]  line_blk;
  logic load, fill_en, wb_evict, wr_en, cap;

  cache_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_split (
    .addr_i(addr_q), .tag_o(req_tag), .idx_o(req_idx), .off_o(req_off)
  );

  cache_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) i_store (
    .clk_i, .rst_ni,
    .idx_i(req_idx), .valid_o(line_valid), .dirty_o(line_dirty),
    .tag_o(line_tag), .blk_o(line_blk),
    .fill_en_i(fill_en), .fill_tag_i(req_tag), .fill_blk_i(fill_data_i),
    .wr_en_i(wr_en), .wr_off_i(req_off), .wr_data_i(wdata_q), .wr_dirty_i(WRITE_BACK)
  );

  cache_ctrl #(.WRITE_BACK(WRITE_BACK)) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .we_i(we_q), .tag_match_i(line_tag == req_tag),
    .line_valid_i(line_valid), .line_dirty_i(line_dirty),
    .fill_ready_i, .wb_ready_i,
    .req_ready_o, .load_o(load), .fill_valid_o, .fill_en_o(fill_en),
    .wb_valid_o, .wb_evict_o(wb_evict), .wr_en_o(wr_en), .cap_o(cap),
    .done_o(rsp_done_o), .hit_o(rsp_hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (cap) rdata_q <= we_q ? wdata_q : line_blk[int'(req_off)*DATA_W +: DATA_W];
    end
  end

  assign rsp_rdata_o = rdata_q;
  assign fill_addr_o = {req_tag, req_idx};
  // eviction copies the whole old block; write-through sends one lane
  assign wb_addr_o   = wb_evict ? {line_tag, req_idx} : {req_tag, req_idx};
  assign wb_data_o   = wb_evict ? line_blk : {WORDS{wdata_q}};
  assign wb_be_o     = wb_evict ? {WORDS{1'b1}} : (WORDS'(1) << req_off);
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W     = 12,
  parameter int OFF_W      = 2,
  parameter int DATA_W     = 8,
  parameter bit WRITE_BACK = 1'b1,
  localparam int WORDS     = 1 << OFF_W,
  localparam int BLK_W     = DATA_W << OFF_W,
  localparam int BADDR_W   = ADDR_W - OFF_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               rsp_done_o,
  input logic               fill_valid_o,
  input logic               fill_ready_i,
  input logic [BADDR_W-1:0] fill_addr_o,
  input logic               wb_valid_o,
  input logic               wb_ready_i,
  input logic [BADDR_W-1:0] wb_addr_o,
  input logic [BLK_W-1:0]   wb_data_o,
  input logic [WORDS-1:0]   wb_be_o
);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  // R5
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> !req_ready_o);
  // R5
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  // R11
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && wb_valid_o));
  // R11
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o && !fill_ready_i |=> fill_valid_o && $stable(fill_addr_o));
  // R11
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_addr_o)
      && $stable(wb_data_o) && $stable(wb_be_o));

  if (WRITE_BACK) begin : g_wb
    // R10
    full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid_o |-> (wb_be_o == {WORDS{1'b1}}));
  end else begin : g_wt
    // R6
    one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid_o |-> ($countones(wb_be_o) == 1));
  end
endmodule

bind dm_cache dm_cache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .WRITE_BACK(WRITE_BACK)
) i_chk (.*);

// File: tb/test_dm_cache.sv
module test_dm_cache;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  // index 0: write-back instance, index 1: write-through instance
  logic       req_v [2];
  logic       req_we;
  logic [3:0] req_addr;
  logic [7:0] req_wd;
  logic       rdy [2], done [2], hit [2];
  logic [7:0] rd [2];
  logic       fv [2], fr [2], wv [2], wr [2];
  logic [2:0] fa [2], wa [2];
  logic [15:0] fd [2], wdat [2];
  logic [1:0] wbe [2];

  dm_cache #(.ADDR_W(4), .IDX_W(2), .OFF_W(1), .DATA_W(8), .WRITE_BACK(1'b1)) i_dm_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v[0]), .req_ready_o(rdy[0]),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wd),
    .rsp_done_o(done[0]), .rsp_hit_o(hit[0]), .rsp_rdata_o(rd[0]),
    .fill_valid_o(fv[0]), .fill_ready_i(fr[0]), .fill_addr_o(fa[0]), .fill_data_i(fd[0]),
    .wb_valid_o(wv[0]), .wb_ready_i(wr[0]), .wb_addr_o(wa[0]), .wb_data_o(wdat[0]), .wb_be_o(wbe[0])
  );

  dm_cache #(.ADDR_W(4), .IDX_W(2), .OFF_W(1), .DATA_W(8), .WRITE_BACK(1'b0)) i_dm_cache_wt (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v[1]), .req_ready_o(rdy[1]),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wd),
    .rsp_done_o(done[1]), .rsp_hit_o(hit[1]), .rsp_rdata_o(rd[1]),
    .fill_valid_o(fv[1]), .fill_ready_i(fr[1]), .fill_addr_o(fa[1]), .fill_data_i(fd[1]),
    .wb_valid_o(wv[1]), .wb_ready_i(wr[1]), .wb_addr_o(wa[1]), .wb_data_o(wdat[1]), .wb_be_o(wbe[1])
  );

  function automatic logic [7:0] ini(int a);
    return 8'(a * 7 + 3);
  endfunction

  // next-level memory models, all activity on the falling edge
  logic [7:0] mem [2][16];
  int fcnt [2], wcnt [2], n_fill [2], n_wb [2], fill_wbcnt [2];
  logic [2:0] last_fa [2], last_wa [2];
  logic [1:0] last_be [2];

  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        fr[k] = 1'b0; wr[k] = 1'b0; fd[k] = '0;
        fcnt[k] = 0; wcnt[k] = 0; n_fill[k] = 0; n_wb[k] = 0; fill_wbcnt[k] = 0;
        last_fa[k] = '0; last_wa[k] = '0; last_be[k] = '0;
        for (int a = 0; a < 16; a++) mem[k][a] = ini(a);
      end else begin
        if (fr[k]) begin
          fr[k] = 1'b0; fcnt[k] = 0;
        end else if (fv[k]) begin
          if (fcnt[k] == LAT) begin
            fr[k] = 1'b1;
            fd[k] = {mem[k][{fa[k], 1'b1}], mem[k][{fa[k], 1'b0}]};
            n_fill[k]++; last_fa[k] = fa[k]; fill_wbcnt[k] = n_wb[k];
          end else fcnt[k]++;
        end
        if (wr[k]) begin
          wr[k] = 1'b0; wcnt[k] = 0;
        end else if (wv[k]) begin
          if (wcnt[k] == LAT) begin
            wr[k] = 1'b1;
            for (int j = 0; j < 2; j++)
              if (wbe[k][j]) mem[k][{wa[k], j[0]}] = wdat[k][8*j +: 8];
            n_wb[k]++; last_wa[k] = wa[k]; last_be[k] = wbe[k];
          end else wcnt[k]++;
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input int k, input bit we, input logic [3:0] a, input logic [7:0] d,
                    output bit h, output logic [7:0] q, output int lat);
    @(negedge clk);
    req_we = we; req_addr = a; req_wd = d; req_v[k] = 1'b1;
    @(negedge clk);
    req_v[k] = 1'b0;
    lat = 1;
    while (!done[k] && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    h = hit[k];
    q = rd[k];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    bit h;
    logic [7:0] q;
    int lat, nf, nw;
    logic [3:0] trace [5];
    bit trace_hit [5];

    trace = '{4'd0, 4'd1, 4'd13, 4'd8, 4'd0};
    trace_hit = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    req_v[0] = 1'b0; req_v[1] = 1'b0; req_we = 1'b0; req_addr = '0; req_wd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R5 reset ready", rdy[k], 1);
      chk("R5 reset done", done[k], 0);
      chk("R11 reset fill_valid", fv[k], 0);
      chk("R11 reset wb_valid", wv[k], 0);
    end

    // R4 trace on the write-back instance
    for (int i = 0; i < 5; i++) begin
      nf = n_fill[0];
      op(0, 1'b0, trace[i], 8'h00, h, q, lat);
      chk("R4 trace hit", h, trace_hit[i]);
      chk("R3 trace data", q, ini(trace[i]));
      chk("R3 refill count", n_fill[0] - nf, trace_hit[i] ? 0 : 1);
      if (trace_hit[i]) chk("R5 hit latency", lat, 2);
      if (trace[i] == 4'd13) chk("R1 refill block of 13", last_fa[0], 6);
    end

    // R2 R3: two full read sweeps on the write-through instance
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 16; a++) begin
        op(1, 1'b0, 4'(a), 8'h00, h, q, lat);
        chk(p == 0 ? "R2 first access" : "R4 conflict sweep", h, a % 2);
        chk("R3 sweep data", q, ini(a));
        if (h) chk("R5 hit latency", lat, 2);
      end
    end

    // R6 write-through write hit
    nf = n_fill[1]; nw = n_wb[1];
    op(1, 1'b1, 4'd14, 8'hA5, h, q, lat);
    chk("R6 wt write hit", h, 1);
    chk("R6 wt write count", n_wb[1] - nw, 1);
    chk("R6 wt write block", last_wa[1], 7);
    chk("R6 wt write mask", last_be[1], 2'b01);
    chk("R6 next level updated", mem[1][14], 8'hA5);
    chk("R6 no refill", n_fill[1] - nf, 0);
    op(1, 1'b0, 4'd14, 8'h00, h, q, lat);
    chk("R6 cached copy hit", h, 1);
    chk("R6 cached copy data", q, 8'hA5);

    // R7 write-through write miss, no allocation
    nf = n_fill[1]; nw = n_wb[1];
    op(1, 1'b1, 4'd3, 8'h3C, h, q, lat);
    chk("R7 wt write miss", h, 0);
    chk("R7 wt write count", n_wb[1] - nw, 1);
    chk("R7 wt write mask", last_be[1], 2'b10);
    chk("R7 wt write block", last_wa[1], 1);
    chk("R7 no refill", n_fill[1] - nf, 0);
    op(1, 1'b0, 4'd3, 8'h00, h, q, lat);
    chk("R7 read after no-allocate", h, 0);
    chk("R7 read data", q, 8'h3C);

    // R8 write-back write hit (set 2 holds block 6)
    nw = n_wb[0];
    op(0, 1'b1, 4'd13, 8'h77, h, q, lat);
    chk("R8 wb write hit", h, 1);
    chk("R8 no next-level write", n_wb[0] - nw, 0);
    chk("R8 write hit latency", lat, 2);
    chk("R8 memory untouched", mem[0][13], ini(13));
    op(0, 1'b0, 4'd13, 8'h00, h, q, lat);
    chk("R8 read back", q, 8'h77);

    // R10 dirty eviction of block 6 by address 5
    nw = n_wb[0];
    op(0, 1'b0, 4'd5, 8'h00, h, q, lat);
    chk("R10 dirty evict miss", h, 0);
    chk("R10 one writeback", n_wb[0] - nw, 1);
    chk("R10 writeback block", last_wa[0], 6);
    chk("R10 writeback mask", last_be[0], 2'b11);
    chk("R10 dirty unit stored", mem[0][13], 8'h77);
    chk("R10 clean unit stored", mem[0][12], ini(12));
    chk("R10 writeback before refill", fill_wbcnt[0], nw + 1);
    chk("R3 data after evict", q, ini(5));

    // R10 clean eviction of block 0 by address 9
    nw = n_wb[0];
    op(0, 1'b0, 4'd9, 8'h00, h, q, lat);
    chk("R10 clean evict miss", h, 0);
    chk("R10 clean evict no write", n_wb[0] - nw, 0);
    chk("R3 data", q, ini(9));

    // R9 write-back write miss allocates
    nf = n_fill[0]; nw = n_wb[0];
    op(0, 1'b1, 4'd7, 8'hC3, h, q, lat);
    chk("R9 write miss reported", h, 0);
    chk("R9 write miss refills", n_fill[0] - nf, 1);
    chk("R9 no write forwarded", n_wb[0] - nw, 0);
    op(0, 1'b0, 4'd7, 8'h00, h, q, lat);
    chk("R9 read after allocate hit", h, 1);
    chk("R9 read after allocate data", q, 8'hC3);
    op(0, 1'b0, 4'd6, 8'h00, h, q, lat);
    chk("R9 neighbour hit", h, 1);
    chk("R9 neighbour data", q, ini(6));
    chk("R8 memory stale", mem[0][7], ini(7));
    op(0, 1'b0, 4'd15, 8'h00, h, q, lat);
    chk("R10 evict allocated block", last_wa[0], 3);
    chk("R10 written unit reaches memory", mem[0][7], 8'hC3);

    // sweep writes then reads on both policies
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < 16; a++) op(k, 1'b1, 4'(a), 8'(a) ^ 8'h5A, h, q, lat);
      for (int a = 0; a < 16; a++) begin
        op(k, 1'b0, 4'(a), 8'h00, h, q, lat);
        chk(k == 0 ? "R9 sweep data" : "R7 sweep data", q, 8'(a) ^ 8'h5A);
      end
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule